// File: doc/BRIEF.md
# Single-Channel Flyby/Two-Cycle DMA Engine

This block is one DMA channel that moves data between memory and an I/O device without the processor. Software-side logic presents a source address, a destination address, a unit count and a set of mode bits. It then pulses `start`. The channel latches all of these and waits for the device's request line. It then asks for the bus and waits for the grant. After that it runs memory cycles on a valid/ready port.

There are two addressing styles. In flyby, one memory cycle carries a whole unit: the device is strobed by `dack` in that same cycle. The memory is either read at the source address (memory to device) or written at the destination address (device to memory). In two-cycle transfers, each unit is a read at the source followed by a write of that data at the destination.

The bus-holding mode sets how long the bus is kept:
- single: the bus is released after each unit;
- single-step: the bus is kept while the device keeps requesting;
- block: the bus is kept until the count runs out.

When the count reaches zero, the channel disables itself and raises a terminal-count flag and a one-cycle interrupt.

The memory port follows valid/ready rules. Once `mem_valid` is high, the channel holds `mem_addr`, `mem_we` and `mem_wdata` steady until a cycle with `mem_ready` high. That cycle is the handshake. `mem_rdata` is taken in the handshake cycle of a read. Memory may stall for any number of cycles. Control and status pins are plain levels.

Top module: `dma_fly_chan`

## Requirements
- R1: After reset, `busy`, `bus_req`, `mem_valid`, `dack`, `tc_flag` and `tc_irq` are all low.
- R2: A `start` pulse seen while idle latches all configuration inputs and enables the channel (`busy` high on the next cycle). A `start` seen while busy is ignored, and so are configuration changes.
- R3: An enabled channel raises `bus_req` on the cycle after it sees `dreq` high. It starts no memory cycle until `bus_gnt` is seen high together with `bus_req`.
- R4: In two-cycle mode (`cfg_flyby`=0), each unit is a read at the source address followed by a write to the destination address. The write carries the data returned by that read.
- R5: In flyby mode (`cfg_flyby`=1), each unit is a single memory cycle. `dack` is high exactly in the cycles where that cycle is presented on the memory port. If `cfg_fly_to_mem`=0 the cycle is a read at the source address; if 1 it is a write at the destination address.
- R6: Address modes, per register: 2'b00 adds 4 after each handshake that used the address, 2'b01 subtracts 4, and 2'b10 or 2'b11 keeps it fixed.
- R7: Bus mode 2'b00 (single) drops `bus_req` after every unit. The next unit needs a fresh request and grant.
- R8: Bus mode 2'b01 (single-step) goes straight on to the next unit while `dreq` is high at the end of a unit. Otherwise it drops `bus_req` and stays enabled until `dreq` returns.
- R9: Bus mode 2'b10 or 2'b11 (block) moves the whole count under one bus ownership, whatever `dreq` does after the grant.
- R10: At the handshake that completes the last unit, the channel clears `busy` and `bus_req` at that edge and pulses `tc_irq` for one cycle. It also sets `tc_flag`, which stays set until the next accepted `start`.
- R11: A `start` with `cfg_count`=0 does not enable the channel. It raises `tc_flag` and pulses `tc_irq` on the next cycle, without any bus request.
- R12: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load configuration and enable (idle only) |
| cfg_src | input | 32 | Source start address |
| cfg_dst | input | 32 | Destination start address |
| cfg_count | input | 16 | Number of units to move |
| cfg_src_mode | input | 2 | Source address mode (R6) |
| cfg_dst_mode | input | 2 | Destination address mode (R6) |
| cfg_flyby | input | 1 | 1 = flyby, 0 = two-cycle |
| cfg_fly_to_mem | input | 1 | Flyby direction: 1 = device to memory |
| cfg_bus_mode | input | 2 | 00 single, 01 single-step, 1x block |
| dreq | input | 1 | Device transfer request |
| dack | output | 1 | Device strobe for a flyby cycle |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| mem_valid | output | 1 | Memory cycle presented |
| mem_ready | input | 1 | Memory accepts/completes the cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data (two-cycle writes) |
| mem_rdata | input | 32 | Read data, valid in a read handshake cycle |
| busy | output | 1 | Channel enabled |
| tc_flag | output | 1 | Terminal count reached (sticky) |
| tc_irq | output | 1 | One-cycle terminal-count pulse |

## Verification
Results are due on this timeline:
- `busy` and a cleared `tc_flag` one edge after the accepted `start`;
- `bus_req` one edge after `dreq` is seen in the enabled state;
- the first memory cycle one edge after the grant;
- each later cycle one edge after the previous handshake;
- `tc_irq`, `tc_flag` and the drop of `busy` on the edge of the final handshake.

The bench drives inputs one nanosecond after a rising edge and reads all outputs on the falling edge. Its memory log records a handshake in the half-cycle before the edge that completes it. Stall and pause checks use a hand-timed `mem_ready` that is high for exactly one edge. This gives exactly one handshake per beat.

// File: rtl/dma_fly_pkg.sv
package dma_fly_pkg;
  typedef enum logic [1:0] {
    AM_INC  = 2'b00,
    AM_DEC  = 2'b01,
    AM_HOLD = 2'b10,
    AM_KEEP = 2'b11
  } amode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_REQ,
    S_RD,
    S_WR,
    S_FLY
  } chan_st_e;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic [1:0]    mode,
  input  logic          adv,
  output logic [AW-1:0] addr
);
  import dma_fly_pkg::*;
  localparam logic [AW-1:0] INCR = AW'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else if (load) addr <= load_val;
    else if (adv) begin
      case (amode_e'(mode))
        AM_INC:  addr <= addr + INCR;
        AM_DEC:  addr <= addr - INCR;
        default: addr <= addr;
      endcase
    end
  end

  AST_FIXED_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && mode[1]) |=> $stable(addr)); // R6
endmodule

// File: rtl/dma_unit_cnt.sv
module dma_unit_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last,
  output logic          empty
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec) cnt <= cnt - ONE;
  end

  assign last  = (cnt == ONE);
  assign empty = (cnt == '0);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !empty); // R10
endmodule

// File: rtl/dma_seq.sv
module dma_seq (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic                  fly,
  input  logic [1:0]            bmode,
  input  logic                  dreq,
  input  logic                  gnt,
  input  logic                  ready,
  input  logic                  last,
  output dma_fly_pkg::chan_st_e state,
  output logic                  unit_done
);
  import dma_fly_pkg::*;
  chan_st_e nxt;
  chan_st_e xfer_st;

  assign xfer_st   = fly ? S_FLY : S_RD;
  assign unit_done = ready && (state == S_WR || state == S_FLY);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (go) nxt = S_ARM;
      S_ARM:  if (dreq) nxt = S_REQ;
      S_REQ:  if (gnt) nxt = xfer_st;
      S_RD:   if (ready) nxt = S_WR;
      S_WR, S_FLY: begin
        if (ready) begin
          if (last) nxt = S_IDLE;
          else if (bmode[1]) nxt = xfer_st;
          else if (bmode[0] && dreq) nxt = xfer_st;
          else nxt = S_ARM;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else state <= nxt;
  end

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR) |-> ($past(state) == S_RD || $past(state) == S_WR)); // R4
  AST_XFER_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_REQ && state != S_REQ) |-> $past(gnt)); // R3
endmodule

// File: rtl/dma_fly_chan.sv
module dma_fly_chan #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_src_mode,
  input  logic [1:0]    cfg_dst_mode,
  input  logic          cfg_flyby,
  input  logic          cfg_fly_to_mem,
  input  logic [1:0]    cfg_bus_mode,
  input  logic          dreq,
  output logic          dack,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          tc_flag,
  output logic          tc_irq
);
  import dma_fly_pkg::*;
  localparam int STEP  = DW / 8;
  localparam int NPTR  = 2;

  chan_st_e state;
  logic unit_done, last, empty, start_acc, go, zero_start, fin, hs;
  logic fly_q, tomem_q;
  logic [1:0] bm_q;
  logic [1:0] am_q [NPTR];
  logic [AW-1:0] ptr_init [NPTR];
  logic [AW-1:0] ptr [NPTR];
  logic [NPTR-1:0] ptr_adv;
  logic [DW-1:0] data_q;

  assign start_acc  = start && (state == S_IDLE);
  assign zero_start = start_acc && (cfg_count == '0);
  assign go         = start_acc && (cfg_count != '0);
  assign hs         = mem_valid && mem_ready;
  assign fin        = unit_done && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fly_q <= 1'b0; tomem_q <= 1'b0; bm_q <= '0;
      am_q[0] <= '0; am_q[1] <= '0;
    end else if (go) begin
      fly_q <= cfg_flyby; tomem_q <= cfg_fly_to_mem; bm_q <= cfg_bus_mode;
      am_q[0] <= cfg_src_mode; am_q[1] <= cfg_dst_mode;
    end
  end

  dma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .fly(fly_q), .bmode(bm_q),
    .dreq(dreq), .gnt(bus_gnt), .ready(mem_ready), .last(last),
    .state(state), .unit_done(unit_done)
  );

  dma_unit_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(go), .load_val(cfg_count),
    .dec(unit_done), .last(last), .empty(empty)
  );

  assign ptr_init[0] = cfg_src;
  assign ptr_init[1] = cfg_dst;
  assign ptr_adv[0]  = hs && (state == S_RD || (state == S_FLY && !tomem_q));
  assign ptr_adv[1]  = hs && (state == S_WR || (state == S_FLY && tomem_q));

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_addr_step #(.AW(AW), .STEP(STEP)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(go), .load_val(ptr_init[g]),
      .mode(am_q[g]), .adv(ptr_adv[g]), .addr(ptr[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (hs && state == S_RD) data_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_flag <= 1'b0; tc_irq <= 1'b0;
    end else begin
      tc_irq <= fin || zero_start;
      if (fin || zero_start) tc_flag <= 1'b1;
      else if (go) tc_flag <= 1'b0;
    end
  end

  assign busy      = (state != S_IDLE);
  assign bus_req   = (state == S_REQ) || (state == S_RD) || (state == S_WR) || (state == S_FLY);
  assign mem_valid = (state == S_RD) || (state == S_WR) || (state == S_FLY);
  assign dack      = (state == S_FLY);
  assign mem_we    = (state == S_WR) || (state == S_FLY && tomem_q);
  assign mem_addr  = mem_we ? ptr[1] : ptr[0];
  assign mem_wdata = data_q;

  AST_DACK_IN_MEM_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (mem_valid && bus_req)); // R5
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12
  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> ($past(bus_gnt) && $past(bus_req))); // R3
  AST_TC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq |-> (!busy && !bus_req && tc_flag)); // R10
  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !empty); // R10
endmodule

// File: tb/tb_dma_fly_chan.sv
module tb_dma_fly_chan;
  localparam logic [31:0] K = 32'h5A5A_0000;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [15:0] cfg_count = '0;
  logic [1:0] cfg_src_mode = '0, cfg_dst_mode = '0, cfg_bus_mode = '0;
  logic cfg_flyby = 1'b0, cfg_fly_to_mem = 1'b0, dreq = 1'b0;
  logic gnt_en = 1'b1, mem_ready = 1'b1;
  logic dack, bus_req, bus_gnt, mem_valid, mem_we, busy, tc_flag, tc_irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  int total = 0, bad = 0;
  int log_n = 0, rel_n = 0, irq_n = 0, dack_bad = 0;
  logic [31:0] lg_addr [0:63];
  logic [31:0] lg_wd [0:63];
  logic lg_we [0:63];
  logic lg_dack [0:63];
  logic prev_req = 1'b0;

  always #2 clk = ~clk;
  assign bus_gnt   = bus_req && gnt_en;
  assign mem_rdata = mem_addr ^ K;

  dma_fly_chan dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
    .cfg_flyby(cfg_flyby), .cfg_fly_to_mem(cfg_fly_to_mem), .cfg_bus_mode(cfg_bus_mode),
    .dreq(dreq), .dack(dack), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .tc_flag(tc_flag),
    .tc_irq(tc_irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_valid && mem_ready) begin
        if (log_n < 64) begin
          lg_addr[log_n] = mem_addr; lg_we[log_n] = mem_we;
          lg_wd[log_n] = mem_wdata; lg_dack[log_n] = dack;
        end
        log_n++;
      end
      if (prev_req && !bus_req) rel_n++;
      prev_req = bus_req;
      if (tc_irq) irq_n++;
      if (dack && !mem_valid) dack_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    log_n = 0; rel_n = 0; irq_n = 0; dack_bad = 0;
  endtask

  task automatic kick(input logic [31:0] s, input logic [31:0] d, input logic [15:0] n,
                      input logic [1:0] sm, input logic [1:0] dm, input logic fly,
                      input logic tomem, input logic [1:0] bm);
    @(posedge clk); #1;
    cfg_src = s; cfg_dst = d; cfg_count = n; cfg_src_mode = sm; cfg_dst_mode = dm;
    cfg_flyby = fly; cfg_fly_to_mem = tomem; cfg_bus_mode = bm; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !bus_req && !mem_valid && !dack && !tc_flag && !tc_irq, "R1 reset outputs",
        {26'd0, busy, bus_req, mem_valid, dack, tc_flag, tc_irq}, 32'd0);
  endtask

  task automatic t_block_two_cycle();
    clear_log(); mem_ready = 1'b1; gnt_en = 1'b1; dreq = 1'b1;
    kick(32'h100, 32'h200, 16'd3, 2'b00, 2'b00, 1'b0, 1'b0, 2'b10);
    chk(busy === 1'b1, "R2 busy after start", {31'd0, busy}, 32'd1);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (bus_req) break; end
    @(posedge clk); #1;
    dreq = 1'b0;
    cfg_src = 32'h900; cfg_count = 16'd9; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    wait_idle();
    chk(log_n == 6, "R9 block unit cycles", log_n, 6);
    for (int k = 0; k < 3; k++) begin
      chk(lg_addr[2*k] == 32'h100 + 4*k && !lg_we[2*k], "R4 read at source", lg_addr[2*k], 32'h100 + 4*k);
      chk(lg_addr[2*k+1] == 32'h200 + 4*k && lg_we[2*k+1], "R6 write at incremented dest", lg_addr[2*k+1], 32'h200 + 4*k);
      chk(lg_wd[2*k+1] == ((32'h100 + 4*k) ^ K), "R4 write carries read data", lg_wd[2*k+1], (32'h100 + 4*k) ^ K);
    end
    chk(rel_n == 1, "R9 one bus ownership", rel_n, 1);
    chk(irq_n == 1 && tc_flag && !busy, "R10 terminal count", irq_n, 1);
    chk(!busy && !bus_req, "R2 start while busy ignored", {30'd0, busy, bus_req}, 0);
  endtask

  task automatic t_flyby_single_to_mem();
    clear_log(); mem_ready = 1'b1; gnt_en = 1'b0; dreq = 1'b1;
    kick(32'h0, 32'h300, 16'd3, 2'b00, 2'b01, 1'b1, 1'b1, 2'b00);
    chk(tc_flag === 1'b0, "R10 flag cleared by start", {31'd0, tc_flag}, 0);
    repeat (8) @(negedge clk);
    chk(bus_req && !mem_valid, "R3 no cycle without grant", {30'd0, bus_req, mem_valid}, 32'd2);
    @(posedge clk); #1;
    gnt_en = 1'b1;
    wait_idle();
    chk(log_n == 3, "R5 one cycle per flyby unit", log_n, 3);
    for (int k = 0; k < 3; k++) begin
      chk(lg_addr[k] == 32'h300 - 4*k, "R6 decrementing dest", lg_addr[k], 32'h300 - 4*k);
      chk(lg_we[k] && lg_dack[k], "R5 flyby write with dack", {30'd0, lg_we[k], lg_dack[k]}, 32'd3);
    end
    chk(dack_bad == 0, "R5 dack only with memory cycle", dack_bad, 0);
    chk(rel_n == 3, "R7 release after each unit", rel_n, 3);
    chk(irq_n == 1, "R10 single irq pulse", irq_n, 1);
  endtask

  task automatic t_step_pause();
    logic [31:0] a0;
    clear_log(); mem_ready = 1'b0; gnt_en = 1'b1; dreq = 1'b1;
    kick(32'h400, 32'h0, 16'd4, 2'b10, 2'b00, 1'b1, 1'b0, 2'b01);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_valid) break; end
    a0 = mem_addr;
    repeat (3) @(negedge clk);
    chk(mem_valid && dack && mem_addr == a0 && !mem_we, "R12 held under stall", mem_addr, a0);
    @(posedge clk); #1; mem_ready = 1'b1;
    @(posedge clk); #1; mem_ready = 1'b0;
    @(negedge clk);
    chk(bus_req && mem_valid, "R8 continues while dreq high", {30'd0, bus_req, mem_valid}, 32'd3);
    @(posedge clk); #1; mem_ready = 1'b1; dreq = 1'b0;
    @(posedge clk); #1; mem_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy && !bus_req && log_n == 2, "R8 pause releases bus", log_n, 2);
    @(posedge clk); #1; mem_ready = 1'b1; dreq = 1'b1;
    wait_idle();
    chk(log_n == 4, "R8 resumes to full count", log_n, 4);
    for (int k = 0; k < 4; k++)
      chk(lg_addr[k] == 32'h400 && !lg_we[k], "R6 fixed source read", lg_addr[k], 32'h400);
    chk(rel_n == 2, "R8 two releases", rel_n, 2);
  endtask

  task automatic t_single_two_cycle();
    clear_log(); mem_ready = 1'b1; gnt_en = 1'b1; dreq = 1'b1;
    kick(32'h500, 32'h600, 16'd2, 2'b01, 2'b11, 1'b0, 1'b0, 2'b00);
    wait_idle();
    chk(log_n == 4, "R7 two units two-cycle", log_n, 4);
    chk(lg_addr[2] == 32'h4FC && !lg_we[2], "R6 decrementing source", lg_addr[2], 32'h4FC);
    chk(lg_addr[3] == 32'h600 && lg_wd[3] == (32'h4FC ^ K), "R4 fixed dest data", lg_wd[3], 32'h4FC ^ K);
    chk(rel_n == 2, "R7 release per unit", rel_n, 2);
    dreq = 1'b0;
  endtask

  task automatic t_zero_count();
    clear_log();
    kick(32'h700, 32'h800, 16'd0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b10);
    chk(tc_irq && tc_flag && !busy, "R11 zero count terminal", {29'd0, tc_irq, tc_flag, busy}, 32'd6);
    @(posedge clk); #1;
    chk(!tc_irq, "R10 irq one cycle", {31'd0, tc_irq}, 0);
    repeat (5) @(negedge clk);
    chk(log_n == 0 && rel_n == 0 && !bus_req, "R11 no bus activity", log_n, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_block_two_cycle();
    t_flyby_single_to_mem();
    t_step_pause();
    t_single_two_cycle();
    t_zero_count();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule